// File: doc/BRIEF.md
# UART Register Front End

This block is the software-facing side of a simple serial port. It exposes 32-bit word registers for the line settings (global, transmit and receive enables, character width, stop bits, parity and a baud divisor), a receive sampling-point value, a transmit data port that feeds a 16-entry FIFO and a receive data port that drains a second 16-entry FIFO. It also holds FIFO occupancy flags, an interrupt mask and a set of latched interrupt causes that software clears by writing ones.

The bit-level shifters sit outside. The transmitter takes characters through a valid/ready pair. The receiver delivers characters with a one-cycle valid strobe and reports framing, parity and break conditions as one-cycle event pulses. The line settings leave the block as plain configuration outputs. Register writes use a one-cycle strobe. A read strobe returns its data on `reg_rdata` one clock later, and that value is held until the next read.

Top module: `uart_regfront`

## Requirements
- R1: After reset every register reads zero except the FIFO info word, which reads 0x0000000A (both FIFOs empty). `irq` and `tx_valid` are low.
- R2: The configuration word at offset 0x00 reads back all 32 bits. Bits [1:0] give the character width code (0..3 for 5..8 bits), bit 2 selects two stop bits, bit 3 selects even parity (0 means odd), bit 4 enables parity, bit 5 enables transmit, bit 6 enables receive and bit 7 is the global enable. Bits [31:8] hold the baud divisor. Each field drives its own output. The sample-point register at 0x08 stores and returns its low 24 bits and drives `cfg_sample`.
- R3: A write to 0x10 queues its low byte. While the global and transmit enables are set, queued bytes are offered on `tx_data` in write order with `tx_valid` high. A byte leaves the queue on a cycle where `tx_valid` and `tx_ready` are both high.
- R4: While the global and receive enables are set, a `rx_valid` strobe queues `rx_data`. A read of 0x14 pops the oldest byte and returns it in bits [7:0] with bit 8 set. A read of 0x14 with the queue empty returns zero and sets cause bit 4 (underrun).
- R5: The FIFO info word at 0x18 shows receive full at bit 0, receive empty at bit 1, transmit full at bit 2 and transmit empty at bit 3. Each FIFO holds 16 entries.
- R6: A write to 0x10 with the transmit FIFO full drops the byte and sets cause bit 0. A receive strobe with the receive FIFO full drops the byte and sets cause bit 3.
- R7: A pulse on `rx_stop_err`, `rx_parity_err` or `rx_break` sets cause bit 1, 2 or 7 respectively.
- R8: Cause bit 5 sets only when the transmit FIFO goes from non-empty to empty. Cause bit 6 sets only when the receive FIFO goes from empty to non-empty. Enabling bit 5 while the FIFO is already empty raises no cause.
- R9: The cause register at 0x24 returns the latched causes. Writing it clears exactly the bits written as one. An event arriving in the same cycle as the clearing write keeps its bit set.
- R10: The interrupt mask at 0x1C uses the same bit positions as the causes. `irq` is high exactly when some cause bit and its mask bit are both set. Causes latch even while masked.
- R11: While the global enable is clear both FIFOs are held empty, `tx_valid` is low and receive strobes are ignored. Bytes queued before the enable was cleared are lost.
- R12: Read data appears on `reg_rdata` one cycle after the read strobe. Offsets 0x04, 0x0C, 0x2C and all other unmapped offsets read zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after `reg_rd` |
| tx_valid | output | 1 | Transmit character available |
| tx_data | output | 8 | Transmit character |
| tx_ready | input | 1 | Transmitter takes the character |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character |
| rx_stop_err | input | 1 | Stop-bit error pulse |
| rx_parity_err | input | 1 | Parity error pulse |
| rx_break | input | 1 | Break detected pulse |
| cfg_uart_en | output | 1 | Global enable |
| cfg_tx_en | output | 1 | Transmit enable |
| cfg_rx_en | output | 1 | Receive enable |
| cfg_parity_en | output | 1 | Parity enable |
| cfg_parity_even | output | 1 | Even parity select |
| cfg_two_stop | output | 1 | Two stop bits select |
| cfg_data_bits | output | 2 | Character width code |
| cfg_baud_div | output | 24 | Baud divisor |
| cfg_sample | output | 24 | Receive sampling point |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit address, 16-entry FIFOs and a 24-bit sampling register. The shallow FIFO depth lets a short random run of transmit writes, receive strobes and data reads reach both full and empty states many times. Those runs exercise the overrun, underrun and edge-triggered empty and non-empty causes against a queue model. Directed steps cover the same-cycle clear-versus-set race and flushing by the global enable.

// File: rtl/uart_regfront_pkg.sv
package uart_regfront_pkg;
    localparam int REG_W  = 32;
    localparam int CHAR_W = 8;
    localparam int NCAUSE = 8;
    localparam int BAUD_W = REG_W - 8;

    // register byte offsets
    localparam int OFF_CFG    = 'h00;
    localparam int OFF_FLOW   = 'h04;
    localparam int OFF_SAMPLE = 'h08;
    localparam int OFF_TUNE   = 'h0C;
    localparam int OFF_TXD    = 'h10;
    localparam int OFF_RXD    = 'h14;
    localparam int OFF_INFO   = 'h18;
    localparam int OFF_MASK   = 'h1C;
    localparam int OFF_CAUSE  = 'h24;
    localparam int OFF_STAT   = 'h2C;

    // configuration bit positions
    localparam int CB_STOP2 = 2;
    localparam int CB_PEVEN = 3;
    localparam int CB_PEN   = 4;
    localparam int CB_TXEN  = 5;
    localparam int CB_RXEN  = 6;
    localparam int CB_EN    = 7;

    // cause bit positions
    localparam int IB_TXOVR  = 0;
    localparam int IB_STOP   = 1;
    localparam int IB_PAR    = 2;
    localparam int IB_RXOVR  = 3;
    localparam int IB_RXUND  = 4;
    localparam int IB_TXEMP  = 5;
    localparam int IB_RXNE   = 6;
    localparam int IB_BREAK  = 7;
endpackage

// File: rtl/uart_regfront_fifo.sv
module uart_regfront_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [AW-1:0]               wp;
        logic [AW-1:0]               rp;
        logic [CW-1:0]               cnt;
    } fifo_st_t;

    fifo_st_t s_d, s_q;
    logic     do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty = (s_q.cnt == '0);
    assign full  = (s_q.cnt == CW'(DEPTH));
    assign head  = s_q.mem[s_q.rp];

    always_comb begin
        s_d     = s_q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (flush) begin
            s_d.wp  = '0;
            s_d.rp  = '0;
            s_d.cnt = '0;
        end else begin
            if (do_push) begin
                s_d.mem[s_q.wp] = push_data;
                s_d.wp          = bump(s_q.wp);
            end
            if (do_pop) begin
                s_d.rp = bump(s_q.rp);
            end
            if (do_push && !do_pop) begin
                s_d.cnt = s_q.cnt + 1'b1;
            end else if (do_pop && !do_push) begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/uart_regfront_cause.sv
module uart_regfront_cause #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    input  logic [N-1:0] mask,
    output logic [N-1:0] status,
    output logic         irq
);
    logic [N-1:0] status_d, status_q;

    always_comb begin
        // a new event outranks a clear in the same cycle
        status_d = (status_q & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= status_d;
        end
    end

    assign status = status_q;
    assign irq    = |(status_q & mask);
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
    import uart_regfront_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int FIFO_DEPTH = 16,
    parameter int SAMPLE_W   = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    output logic                tx_valid,
    output logic [CHAR_W-1:0]   tx_data,
    input  logic                tx_ready,
    input  logic                rx_valid,
    input  logic [CHAR_W-1:0]   rx_data,
    input  logic                rx_stop_err,
    input  logic                rx_parity_err,
    input  logic                rx_break,
    output logic                cfg_uart_en,
    output logic                cfg_tx_en,
    output logic                cfg_rx_en,
    output logic                cfg_parity_en,
    output logic                cfg_parity_even,
    output logic                cfg_two_stop,
    output logic [1:0]          cfg_data_bits,
    output logic [BAUD_W-1:0]   cfg_baud_div,
    output logic [SAMPLE_W-1:0] cfg_sample,
    output logic                irq
);
    typedef struct packed {
        logic [REG_W-1:0]    cfg;
        logic [SAMPLE_W-1:0] sample;
        logic [NCAUSE-1:0]   ie;
        logic [REG_W-1:0]    rdata;
        logic                txe_prev;
        logic                rxe_prev;
    } st_t;

    localparam st_t ST_RESET = '{cfg: '0, sample: '0, ie: '0, rdata: '0,
                                 txe_prev: 1'b1, rxe_prev: 1'b1};

    st_t s_d, s_q;

    logic               hit_cfg, hit_sample, hit_txd, hit_rxd;
    logic               hit_info, hit_mask, hit_cause;
    logic               run, tx_on, rx_on;
    logic               tx_push_req, tx_pop, tx_empty, tx_full;
    logic               rx_push, rx_rd, rx_pop, rx_empty, rx_full;
    logic [CHAR_W-1:0]  tx_head, rx_head;
    logic [NCAUSE-1:0]  set_vec, clr_vec, cause_status, ie_mask;

    // address decode
    assign hit_cfg    = (reg_addr == ADDR_W'(OFF_CFG));
    assign hit_sample = (reg_addr == ADDR_W'(OFF_SAMPLE));
    assign hit_txd    = (reg_addr == ADDR_W'(OFF_TXD));
    assign hit_rxd    = (reg_addr == ADDR_W'(OFF_RXD));
    assign hit_info   = (reg_addr == ADDR_W'(OFF_INFO));
    assign hit_mask   = (reg_addr == ADDR_W'(OFF_MASK));
    assign hit_cause  = (reg_addr == ADDR_W'(OFF_CAUSE));

    assign run   = s_q.cfg[CB_EN];
    assign tx_on = run && s_q.cfg[CB_TXEN];
    assign rx_on = run && s_q.cfg[CB_RXEN];

    assign tx_push_req = reg_wr && hit_txd;
    assign tx_valid    = tx_on && !tx_empty;
    assign tx_pop      = tx_valid && tx_ready;
    assign tx_data     = tx_head;

    assign rx_push = rx_valid && rx_on;
    assign rx_rd   = reg_rd && hit_rxd;
    assign rx_pop  = rx_rd && !rx_empty;

    assign ie_mask = s_q.ie;

    uart_regfront_fifo #(.WIDTH(CHAR_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (!run),
        .push      (tx_push_req),
        .push_data (reg_wdata[CHAR_W-1:0]),
        .pop       (tx_pop),
        .head      (tx_head),
        .empty     (tx_empty),
        .full      (tx_full)
    );

    uart_regfront_fifo #(.WIDTH(CHAR_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (!run),
        .push      (rx_push),
        .push_data (rx_data),
        .pop       (rx_pop),
        .head      (rx_head),
        .empty     (rx_empty),
        .full      (rx_full)
    );

    // event vector in cause bit order
    always_comb begin
        set_vec            = '0;
        set_vec[IB_TXOVR]  = tx_push_req && run && tx_full;
        set_vec[IB_STOP]   = rx_stop_err;
        set_vec[IB_PAR]    = rx_parity_err;
        set_vec[IB_RXOVR]  = rx_push && rx_full;
        set_vec[IB_RXUND]  = rx_rd && rx_empty;
        set_vec[IB_TXEMP]  = tx_empty && !s_q.txe_prev;
        set_vec[IB_RXNE]   = !rx_empty && s_q.rxe_prev;
        set_vec[IB_BREAK]  = rx_break;
        clr_vec            = (reg_wr && hit_cause) ? reg_wdata[NCAUSE-1:0] : '0;
    end

    uart_regfront_cause #(.N(NCAUSE)) u_cause (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .mask    (ie_mask),
        .status  (cause_status),
        .irq     (irq)
    );

    always_comb begin
        s_d          = s_q;
        s_d.txe_prev = tx_empty;
        s_d.rxe_prev = rx_empty;

        if (reg_wr) begin
            if (hit_cfg)    s_d.cfg    = reg_wdata;
            if (hit_sample) s_d.sample = reg_wdata[SAMPLE_W-1:0];
            if (hit_mask)   s_d.ie     = reg_wdata[NCAUSE-1:0];
        end

        if (reg_rd) begin
            s_d.rdata = '0;
            if (hit_cfg) begin
                s_d.rdata = s_q.cfg;
            end else if (hit_sample) begin
                s_d.rdata = REG_W'(s_q.sample);
            end else if (hit_rxd) begin
                s_d.rdata = rx_empty ? '0 :
                            REG_W'({1'b1, rx_head});
            end else if (hit_info) begin
                s_d.rdata = REG_W'({tx_empty, tx_full, rx_empty, rx_full});
            end else if (hit_mask) begin
                s_d.rdata = REG_W'(s_q.ie);
            end else if (hit_cause) begin
                s_d.rdata = REG_W'(cause_status);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= ST_RESET;
        end else begin
            s_q <= s_d;
        end
    end

    assign reg_rdata       = s_q.rdata;
    assign cfg_uart_en     = s_q.cfg[CB_EN];
    assign cfg_tx_en       = s_q.cfg[CB_TXEN];
    assign cfg_rx_en       = s_q.cfg[CB_RXEN];
    assign cfg_parity_en   = s_q.cfg[CB_PEN];
    assign cfg_parity_even = s_q.cfg[CB_PEVEN];
    assign cfg_two_stop    = s_q.cfg[CB_STOP2];
    assign cfg_data_bits   = s_q.cfg[1:0];
    assign cfg_baud_div    = s_q.cfg[REG_W-1:8];
    assign cfg_sample      = s_q.sample;
endmodule

// File: rtl/uart_regfront_chk.sv
module uart_regfront_chk
    import uart_regfront_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [REG_W-1:0]  reg_wdata,
    input logic [REG_W-1:0]  reg_rdata,
    input logic              tx_valid,
    input logic [CHAR_W-1:0] tx_data,
    input logic              tx_ready,
    input logic              cfg_uart_en,
    input logic              irq,
    input logic              rx_break,
    input logic [NCAUSE-1:0] ie_mask,
    input logic [NCAUSE-1:0] cause_status,
    input logic              tx_full,
    input logic              rx_empty
);
    logic a_txd, a_rxd, a_cfg, a_cause;
    assign a_txd   = (reg_addr == ADDR_W'(OFF_TXD));
    assign a_rxd   = (reg_addr == ADDR_W'(OFF_RXD));
    assign a_cfg   = (reg_addr == ADDR_W'(OFF_CFG));
    assign a_cause = (reg_addr == ADDR_W'(OFF_CAUSE));

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !(reg_wr && a_cfg)) |=> (tx_valid && $stable(tx_data))); // R3

    AST_RX_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && a_rxd && rx_empty) |=> cause_status[IB_RXUND]); // R4

    AST_RX_VALID_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && a_rxd) |=> (reg_rdata[8] == !$past(rx_empty) && reg_rdata[31:9] == '0)); // R4

    AST_TX_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && a_txd && tx_full && cfg_uart_en) |=> cause_status[IB_TXOVR]); // R6

    AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && a_cause && reg_wdata[IB_BREAK] && !rx_break) |=> !cause_status[IB_BREAK]); // R9

    AST_NO_MASK_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_mask == '0) |-> !irq); // R10

    AST_FLUSH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_uart_en |=> !tx_valid); // R11
endmodule

bind uart_regfront uart_regfront_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_rd       (reg_rd),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .tx_valid     (tx_valid),
    .tx_data      (tx_data),
    .tx_ready     (tx_ready),
    .cfg_uart_en  (cfg_uart_en),
    .irq          (irq),
    .rx_break     (rx_break),
    .ie_mask      (ie_mask),
    .cause_status (cause_status),
    .tx_full      (tx_full),
    .rx_empty     (rx_empty)
);

// File: tb/sim_uart_regfront.sv
module sim_uart_regfront;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;

    localparam logic [7:0] A_CFG = 8'h00, A_FLOW = 8'h04, A_SMP = 8'h08, A_TUNE = 8'h0C;
    localparam logic [7:0] A_TXD = 8'h10, A_RXD = 8'h14, A_INFO = 8'h18, A_IE = 8'h1C;
    localparam logic [7:0] A_IST = 8'h24, A_STAT = 8'h2C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_stop_err = 1'b0, rx_parity_err = 1'b0, rx_break = 1'b0;
    logic        cfg_uart_en, cfg_tx_en, cfg_rx_en, cfg_parity_en, cfg_parity_even, cfg_two_stop;
    logic [1:0]  cfg_data_bits;
    logic [23:0] cfg_baud_div, cfg_sample;
    logic        irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_regfront u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data), .rx_stop_err(rx_stop_err),
        .rx_parity_err(rx_parity_err), .rx_break(rx_break), .cfg_uart_en(cfg_uart_en),
        .cfg_tx_en(cfg_tx_en), .cfg_rx_en(cfg_rx_en), .cfg_parity_en(cfg_parity_en),
        .cfg_parity_even(cfg_parity_even), .cfg_two_stop(cfg_two_stop),
        .cfg_data_bits(cfg_data_bits), .cfg_baud_div(cfg_baud_div), .cfg_sample(cfg_sample),
        .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] info_word(input int txn, input int rxn);
        return {28'd0, txn == 0, txn == DEPTH, rxn == 0, rxn == DEPTH};
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic rxpush(input logic [7:0] b);
        rx_valid = 1'b1; rx_data = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic drain(output logic [7:0] got[$]);
        got = {};
        tx_ready = 1'b1;
        repeat (DEPTH + 4) begin
            if (tx_valid) got.push_back(tx_data);
            @(negedge clk);
        end
        tx_ready = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [7:0]  got[$];
        logic [7:0]  txq[$];
        logic [7:0]  rxq[$];
        logic [7:0]  mist;

        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 tx_valid", {31'd0, tx_valid}, 32'd0);
        check("R1 irq", {31'd0, irq}, 32'd0);
        rd(A_CFG, d);  check("R1 cfg", d, 32'd0);
        rd(A_INFO, d); check("R1 info", d, 32'h0000_000A);
        rd(A_IST, d);  check("R1 cause", d, 32'd0);

        // R12 reserved offsets
        wr(A_FLOW, 32'hFFFF_FFFF); wr(A_TUNE, 32'h1234_5678); wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_FLOW, d); check("R12 flow offset", d, 32'd0);
        rd(A_TUNE, d); check("R12 tune offset", d, 32'd0);
        rd(A_STAT, d); check("R12 status offset", d, 32'd0);
        rd(A_CFG, d);  check("R12 cfg untouched", d, 32'd0);

        // R2 configuration fields
        wr(A_CFG, 32'h0001_20F9);
        check("R2 data bits", {30'd0, cfg_data_bits}, 32'd1);
        check("R2 flags", {26'd0, cfg_uart_en, cfg_rx_en, cfg_tx_en, cfg_parity_en,
                           cfg_parity_even, cfg_two_stop}, 32'b111110);
        check("R2 baud", {8'd0, cfg_baud_div}, 32'h0000_0120);
        rd(A_CFG, d); check("R2 cfg readback", d, 32'h0001_20F9);
        wr(A_CFG, 32'h00AB_CD1E);
        check("R2 data bits b", {30'd0, cfg_data_bits}, 32'd2);
        check("R2 flags b", {26'd0, cfg_uart_en, cfg_rx_en, cfg_tx_en, cfg_parity_en,
                             cfg_parity_even, cfg_two_stop}, 32'b000111);
        check("R2 baud b", {8'd0, cfg_baud_div}, 32'h00AB_CD);
        wr(A_SMP, 32'hFF00_0090);
        rd(A_SMP, d); check("R2 sample readback", d, 32'h0000_0090);
        check("R2 sample out", {8'd0, cfg_sample}, 32'h0000_0090);

        wr(A_CFG, 32'h0001_00E3);

        // R8 enabling TX-empty on an empty FIFO gives nothing
        wr(A_IE, 32'h20); idle(3);
        rd(A_IST, d); check("R8 no event on already empty", d, 32'd0);
        check("R8 irq idle", {31'd0, irq}, 32'd0);

        // R4 receive path
        rxpush(8'h5A); idle(2);
        rd(A_INFO, d); check("R5 info rx nonempty", d, 32'h0000_0008);
        rd(A_RXD, d);  check("R4 rx data valid", d, 32'h0000_015A);
        rd(A_RXD, d);  check("R4 rx empty read", d, 32'd0);
        rd(A_IST, d);  check("R4 underrun and R8 rx nonempty", d, 32'h0000_0050);
        check("R10 masked cause no irq", {31'd0, irq}, 32'd0);

        // R10 mask enables irq
        wr(A_IE, 32'h10);
        check("R10 irq on mask", {31'd0, irq}, 32'd1);

        // R9 write one to clear
        wr(A_IST, 32'h10);
        rd(A_IST, d); check("R9 clear one bit", d, 32'h0000_0040);
        check("R10 irq after clear", {31'd0, irq}, 32'd0);
        wr(A_IST, 32'h40);
        rd(A_IST, d); check("R9 clear rest", d, 32'd0);

        // R7 event pulses, R9 set beats clear
        rx_break = 1'b1; @(negedge clk); rx_break = 1'b0;
        rd(A_IST, d); check("R7 break", d, 32'h0000_0080);
        rx_break = 1'b1; wr(A_IST, 32'h80); rx_break = 1'b0;
        rd(A_IST, d); check("R9 set wins over clear", d, 32'h0000_0080);
        wr(A_IST, 32'h80);
        rd(A_IST, d); check("R9 break cleared", d, 32'd0);
        rx_stop_err = 1'b1; rx_parity_err = 1'b1; @(negedge clk);
        rx_stop_err = 1'b0; rx_parity_err = 1'b0;
        rd(A_IST, d); check("R7 stop and parity", d, 32'h0000_0006);
        wr(A_IST, 32'hFF);

        // R3 transmit order, R8 tx empty edge
        wr(A_TXD, 32'hFFFF_FF11); wr(A_TXD, 32'h22); wr(A_TXD, 32'h33); idle(1);
        check("R3 tx valid", {31'd0, tx_valid}, 32'd1);
        check("R3 tx head", {24'd0, tx_data}, 32'h11);
        rd(A_INFO, d); check("R5 info tx nonempty", d, 32'h0000_0002);
        drain(got);
        check("R3 tx count", got.size(), 32'd3);
        if (got.size() == 3) begin
            check("R3 tx byte0", {24'd0, got[0]}, 32'h11);
            check("R3 tx byte1", {24'd0, got[1]}, 32'h22);
            check("R3 tx byte2", {24'd0, got[2]}, 32'h33);
        end
        idle(2);
        rd(A_IST, d); check("R8 tx empty event", d, 32'h0000_0020);
        wr(A_IE, 32'h20);
        check("R10 irq tx empty", {31'd0, irq}, 32'd1);
        wr(A_IST, 32'hFF); wr(A_IE, 32'h00);

        // R5 full flags, R6 overruns
        for (int i = 0; i < DEPTH; i++) wr(A_TXD, 32'(i + 8'h40));
        for (int i = 0; i < DEPTH; i++) rxpush(8'(i + 8'h80));
        idle(2);
        rd(A_INFO, d); check("R5 info both full", d, 32'h0000_0005);
        wr(A_TXD, 32'hEE); rxpush(8'hEE); idle(2);
        rd(A_IST, d); check("R6 overruns", d, 32'h0000_0049);
        for (int i = 0; i < DEPTH; i++) begin
            rd(A_RXD, d); check("R6 rx order after drop", d, 32'h100 | 32'(i + 8'h80));
        end
        rd(A_RXD, d); check("R6 extra byte dropped", d, 32'd0);
        wr(A_IST, 32'hFF);

        // R11 flush by global enable
        rxpush(8'h01); rxpush(8'h02);
        wr(A_CFG, 32'h0001_0060); idle(1);
        check("R11 tx stopped", {31'd0, tx_valid}, 32'd0);
        rxpush(8'h77);
        wr(A_CFG, 32'h0001_00E3); idle(2);
        rd(A_INFO, d); check("R11 fifos flushed", d, 32'h0000_000A);
        rd(A_RXD, d);  check("R11 rx strobe ignored", d, 32'd0);
        check("R11 tx idle after enable", {31'd0, tx_valid}, 32'd0);
        idle(2);
        wr(A_IST, 32'hFF);

        // random phase against a queue model
        mist = '0;
        for (int n = 0; n < 400; n++) begin
            int op;
            logic [7:0] b;
            op = int'($urandom % 4);
            b  = 8'($urandom);
            case (op)
                0: begin
                    wr(A_TXD, {24'd0, b});
                    if (txq.size() == DEPTH) mist[0] = 1'b1; else txq.push_back(b);
                end
                1: begin
                    rxpush(b);
                    if (rxq.size() == DEPTH) mist[3] = 1'b1;
                    else begin
                        if (rxq.size() == 0) mist[6] = 1'b1;
                        rxq.push_back(b);
                    end
                end
                2: begin
                    rd(A_RXD, d);
                    if (rxq.size() == 0) begin
                        mist[4] = 1'b1;
                        check("R4 random empty read", d, 32'd0);
                    end else begin
                        check("R4 random rx data", d, 32'h100 | 32'(rxq.pop_front()));
                    end
                end
                default: begin
                    rd(A_INFO, d);
                    check("R5 random info", d, info_word(txq.size(), rxq.size()));
                end
            endcase
            idle(2);
        end
        if (txq.size() != 0) mist[5] = 1'b1;
        drain(got);
        check("R3 random tx count", got.size(), txq.size());
        for (int i = 0; i < got.size() && i < txq.size(); i++)
            check("R3 random tx byte", {24'd0, got[i]}, {24'd0, txq[i]});
        idle(2);
        rd(A_IST, d); check("R6 R8 random causes", d, {24'd0, mist});

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule